// File: doc/BRIEF.md
# Multi-Channel Programmable Interval Timer Bank

This block holds a set of independent down-counting timers (six by default) behind one register port. The port takes a single-cycle write strobe or read strobe. Each timer has three registers: a control word, a reload interval and a live count. The control word picks one of four tick-enable inputs as the timer's time base. It also picks a power-of-two prescale, a periodic or one-shot mode, and a run bit.

When a running timer expires, it sets its bit in a shared interrupt-status register. A periodic timer then reloads its count from the interval and keeps counting. A one-shot timer stops and clears its own run bit. Each timer drives its own interrupt line, and that line is high whenever both its status bit and its bit in the shared interrupt-enable register are set. Software clears status bits by writing ones to them.

The register map has the enable word at 0x00 and the status word at 0x04. Timer i occupies the 16-byte slot that starts at 0x10*(i+1). Within a slot, the control word is at +0x0, the interval at +0x4 and the count at +0x8.

Top module: `pit_bank`

## Requirements
- R1: After reset the enable, status, interval and count registers read 0, every control register reads 0x04 (source 1, prescale 1, stopped, periodic), and all interrupt lines are low.
- R2: Interrupt line i is high exactly when status bit i and enable bit i are both set. The line follows an enable write, a status write or an expiry in the cycle after the triggering edge.
- R3: Writing the status register clears each status bit whose data bit is 1 and leaves the other bits as they were. Reading it returns the current bits.
- R4: A read returns data one cycle after the read strobe. Timer index is address bits [7:4] minus 1, and address bits [3:0] select the control (0x0), interval (0x4) or count (0x8) word. Any other address reads as 0, and writes to it change nothing.
- R5: Control bits [3:2] select which of the four tick-enable inputs advances the timer. Pulses on the other three inputs have no effect, so a selected input that is held low never advances the counter.
- R6: Control bits [6:4] hold a prescale exponent p. A running timer counts once per 2^p selected ticks, and the prescale phase restarts on every control write.
- R7: Control bit 0 is the run bit. A control write with bit 0 set starts the timer, and a control write with bit 0 clear stops it. A stopped timer holds its count.
- R8: Each counted tick lowers the count by one. A counted tick that arrives while the count is 1 or 0 is an expiry, and an expiry sets that timer's status bit.
- R9: With control bit 7 clear (periodic), an expiry reloads the count from the interval and the timer keeps running, so it expires once every interval ticks.
- R10: With control bit 7 set (one-shot), an expiry leaves the count at 0 and clears the run bit in the control register, and the timer stays stopped.
- R11: A control write with bit 1 set loads the count from the interval register.
- R12: An interval write sets both the interval and the count. Writes to the count register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 4 | Tick-enable time-base inputs, one per clock source |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| irq_o | output | N_TIMERS | Interrupt line for each timer |

## Verification
The assertions assume that the strobes and the address come from a single master. They also assume that at most one register access is made per cycle, so a control or interval write never races a second write to the same timer. The status-clear and reload properties are stated only for cycles in which no expiry, or no register write to that timer, coincides with the event they check. The bench therefore drives the tick inputs, the strobes and the address one at a time on the falling edge. It also keeps every register access apart from the tick pulses.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int CTRL_W  = 8;
    localparam int SRC_N   = 4;
    localparam int SRC_W   = 2;
    localparam int PEXP_W  = 3;

    // control word, bit 0 upward: run, reload, source[1:0], prescale[2:0], one-shot
    typedef struct packed {
        logic              oneshot;
        logic [PEXP_W-1:0] pexp;
        logic [SRC_W-1:0]  src;
        logic              reload;
        logic              run;
    } ctrl_t;

    localparam logic [CTRL_W-1:0] CTRL_RST = 8'h04;

    localparam logic [3:0] SLOT_CTRL = 4'h0;
    localparam logic [3:0] SLOT_INTV = 4'h4;
    localparam logic [3:0] SLOT_CNT  = 4'h8;

    localparam logic [3:0] GLB_IEN   = 4'h0;
    localparam logic [3:0] GLB_IST   = 4'h4;

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_in,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick_out
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] phase_d, phase_q;
    logic [CNT_W-1:0] mask;
    logic             wrap;

    always_comb begin
        for (int b = 0; b < CNT_W; b++) begin
            mask[b] = (b < int'(exp_sel));
        end
        wrap     = ((phase_q & mask) == mask);
        tick_out = tick_in && !clr && wrap;
        phase_d  = phase_q;
        if (clr) begin
            phase_d = '0;
        end else if (tick_in) begin
            phase_d = wrap ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_tick,
    input  logic              wr_ctrl,
    input  logic              wr_intv,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] intv_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic              expire_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] intv;
        logic [DATA_W-1:0] cnt;
    } chan_t;

    chan_t st_d, st_q;
    logic  sel_tick;
    logic  pre_in;
    logic  cnt_tick;
    logic  any_wr;

    assign any_wr   = wr_ctrl | wr_intv;
    assign sel_tick = src_tick[st_q.ctrl.src];
    assign pre_in   = st_q.ctrl.run & sel_tick & !any_wr;

    pit_prescaler #(
        .EXP_W (PEXP_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wr_ctrl),
        .tick_in  (pre_in),
        .exp_sel  (st_q.ctrl.pexp),
        .tick_out (cnt_tick)
    );

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (wr_ctrl) begin
            st_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
            if (wdata[1]) begin
                st_d.cnt = st_q.intv;
            end
        end else if (wr_intv) begin
            st_d.intv = wdata;
            st_d.cnt  = wdata;
        end else if (cnt_tick) begin
            if (st_q.cnt <= DATA_W'(1)) begin
                expire_o = 1'b1;
                if (st_q.ctrl.oneshot) begin
                    st_d.cnt      = '0;
                    st_d.ctrl.run = 1'b0;
                end else begin
                    st_d.cnt = st_q.intv;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= ctrl_t'(CTRL_RST);
            st_q.intv <= '0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign intv_o = st_q.intv;
    assign cnt_o  = st_q.cnt;

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && st_q.ctrl.oneshot) |=> (!st_q.ctrl.run && st_q.cnt == '0)); // R10

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !st_q.ctrl.oneshot) |=> (st_q.cnt == $past(st_q.intv) && st_q.ctrl.run)); // R9

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.run && !any_wr) |=> $stable(st_q.cnt)); // R7

    AST_INTV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_intv |=> (st_q.intv == $past(wdata) && st_q.cnt == $past(wdata))); // R12

    AST_RELOAD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[1]) |=> (st_q.cnt == $past(st_q.intv))); // R11

endmodule

// File: rtl/pit_bank.sv
module pit_bank
    import pit_pkg::*;
#(
    parameter int N_TIMERS = 6,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          tick_en,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [N_TIMERS-1:0] irq_o
);
    localparam int HI_W = ADDR_W - 4;

    typedef struct packed {
        logic [N_TIMERS-1:0] ien;
        logic [N_TIMERS-1:0] ist;
        logic [DATA_W-1:0]   rdata;
    } bank_t;

    bank_t st_d, st_q;

    logic [HI_W-1:0]     hi;
    logic [3:0]          lo;
    logic                glb_sel;
    logic                wr_ien, wr_ist;
    logic                mapped;
    logic [DATA_W-1:0]   rd_mux;
    logic [N_TIMERS-1:0] tmr_sel;
    logic [N_TIMERS-1:0] wr_ctrl, wr_intv;
    logic [N_TIMERS-1:0] expire;
    logic [CTRL_W-1:0]   ctrl_v [N_TIMERS];
    logic [DATA_W-1:0]   intv_v [N_TIMERS];
    logic [DATA_W-1:0]   cnt_v  [N_TIMERS];

    assign hi      = addr[ADDR_W-1:4];
    assign lo      = addr[3:0];
    assign glb_sel = (hi == '0);
    assign wr_ien  = wr_en && glb_sel && lo == GLB_IEN;
    assign wr_ist  = wr_en && glb_sel && lo == GLB_IST;

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
        assign tmr_sel[i] = (hi == HI_W'(i + 1));
        assign wr_ctrl[i] = wr_en && tmr_sel[i] && lo == SLOT_CTRL;
        assign wr_intv[i] = wr_en && tmr_sel[i] && lo == SLOT_INTV;

        pit_channel #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_tick (tick_en),
            .wr_ctrl  (wr_ctrl[i]),
            .wr_intv  (wr_intv[i]),
            .wdata    (wdata),
            .ctrl_o   (ctrl_v[i]),
            .intv_o   (intv_v[i]),
            .cnt_o    (cnt_v[i]),
            .expire_o (expire[i])
        );
    end

    always_comb begin
        rd_mux = '0;
        mapped = 1'b0;
        if (glb_sel) begin
            if (lo == GLB_IEN) begin
                rd_mux = DATA_W'(st_q.ien);
                mapped = 1'b1;
            end else if (lo == GLB_IST) begin
                rd_mux = DATA_W'(st_q.ist);
                mapped = 1'b1;
            end
        end
        for (int i = 0; i < N_TIMERS; i++) begin
            if (tmr_sel[i]) begin
                if (lo == SLOT_CTRL) begin
                    rd_mux = DATA_W'(ctrl_v[i]);
                    mapped = 1'b1;
                end else if (lo == SLOT_INTV) begin
                    rd_mux = intv_v[i];
                    mapped = 1'b1;
                end else if (lo == SLOT_CNT) begin
                    rd_mux = cnt_v[i];
                    mapped = 1'b1;
                end
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = rd_en ? rd_mux : '0;
        if (wr_ien) begin
            st_d.ien = wdata[N_TIMERS-1:0];
        end
        if (wr_ist) begin
            st_d.ist = st_q.ist & ~wdata[N_TIMERS-1:0];
        end
        st_d.ist = st_d.ist | expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign irq_o = st_q.ist & st_q.ien;

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ist && expire == '0) |=> ((st_q.ist & $past(wdata[N_TIMERS-1:0])) == '0)); // R3

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ist |=> (($past(st_q.ist) & ~st_q.ist) == '0)); // R3

    AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire != '0) |=> ((st_q.ist & $past(expire)) == $past(expire))); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rdata == '0)); // R4

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_ien, wr_ist, wr_ctrl, wr_intv}) <= 1); // R4

endmodule

// File: tb/pit_bank_tb.sv
module pit_bank_tb;
    localparam int NT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    tick_en = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NT-1:0] irq_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pit_bank #(.N_TIMERS(NT), .DATA_W(32), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
        v = rdata;
    endtask

    task automatic pulse(input int src, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en[src] = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tick_en[src] = 1'b0;
        end
    endtask

    function automatic logic [7:0] base(input int t);
        return 8'((t + 1) * 16);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 32'(irq_o), 0);
        rd(8'h00, v); chk("R1 ien", v, 0);
        rd(8'h04, v); chk("R1 ist", v, 0);
        for (int t = 0; t < NT; t++) begin
            rd(base(t) + 8'h0, v); chk("R1 ctrl", v, 32'h04);
            rd(base(t) + 8'h4, v); chk("R1 intv", v, 0);
            rd(base(t) + 8'h8, v); chk("R1 cnt", v, 0);
        end

        // R4 / R12 address map, interval loads count
        for (int t = 0; t < NT; t++) wr(base(t) + 8'h4, 32'(100 + t));
        for (int t = 0; t < NT; t++) begin
            rd(base(t) + 8'h4, v); chk("R4 intv map", v, 32'(100 + t));
            rd(base(t) + 8'h8, v); chk("R12 cnt load", v, 32'(100 + t));
        end
        wr(8'h70, 32'hFF); wr(8'h0C, 32'hFF); wr(8'h14, 32'hFF);
        rd(8'h70, v); chk("R4 unmapped 70", v, 0);
        rd(8'hF4, v); chk("R4 unmapped F4", v, 0);
        rd(8'h0C, v); chk("R4 unmapped 0C", v, 0);
        rd(8'h00, v); chk("R4 ien untouched", v, 0);
        rd(8'h10, v); chk("R4 ctrl untouched", v, 32'h04);
        // 0x14 is timer 0 slot +4 = interval, so that write is mapped
        rd(8'h14, v); chk("R4 intv write", v, 32'hFF);
        wr(8'h18, 32'd55);
        rd(8'h18, v); chk("R12 cnt write ignored", v, 32'hFF);

        // sweep: timer x prescale, periodic, source t%4
        for (int t = 0; t < NT; t++) begin
            for (int p = 0; p < 3; p++) begin
                int s;
                int sc;
                s  = t % 4;
                sc = 1 << p;
                wr(base(t) + 8'h4, 32'd3);
                wr(base(t), 32'(1 | (s << 2) | (p << 4)));
                for (int o = 1; o < 4; o++) pulse((s + o) % 4, 3);
                rd(base(t) + 8'h8, v); chk("R5 other sources", v, 3);
                if (sc > 1) begin
                    pulse(s, sc - 1);
                    rd(base(t) + 8'h8, v); chk("R6 prescale hold", v, 3);
                    pulse(s, 1);
                end else begin
                    pulse(s, 1);
                end
                rd(base(t) + 8'h8, v); chk("R8 decrement", v, 2);
                pulse(s, sc);
                rd(8'h04, v); chk("R8 no early expiry", v, 0);
                pulse(s, sc);
                rd(8'h04, v); chk("R8 status set", v, 32'(1 << t));
                rd(base(t) + 8'h8, v); chk("R9 reload", v, 3);
                chk("R2 masked irq", 32'(irq_o), 0);
                wr(base(t), 32'(s << 2));
                pulse(s, 4);
                rd(base(t) + 8'h8, v); chk("R7 hold stopped", v, 3);
                wr(8'h04, 32'(1 << t));
                rd(8'h04, v); chk("R3 clear", v, 0);
            end
        end

        // R9 several periods, interval 2, source 0
        wr(base(4) + 8'h4, 32'd2);
        wr(base(4), 32'h01);
        for (int k = 0; k < 3; k++) begin
            pulse(0, 1);
            rd(8'h04, v); chk("R9 mid period", v, 0);
            pulse(0, 1);
            rd(8'h04, v); chk("R9 period expiry", v, 32'(1 << 4));
            wr(8'h04, 32'h3F);
        end
        wr(base(4), 32'h00);

        // R2 / R3 interrupt gating and write-one-to-clear
        wr(8'h00, 32'h3F);
        wr(base(0) + 8'h4, 32'd1);
        wr(base(1) + 8'h4, 32'd1);
        wr(base(0), 32'h01);
        wr(base(1), 32'h01);
        pulse(0, 1);
        chk("R2 both irq", 32'(irq_o), 32'h03);
        wr(8'h00, 32'h01);
        chk("R2 enable mask", 32'(irq_o), 32'h01);
        wr(8'h04, 32'h01);
        rd(8'h04, v); chk("R3 partial clear", v, 32'h02);
        chk("R2 after clear", 32'(irq_o), 0);
        wr(8'h00, 32'h3F);
        chk("R2 re-enable", 32'(irq_o), 32'h02);
        wr(base(0), 32'h00);
        wr(base(1), 32'h00);
        wr(8'h04, 32'h3F);
        chk("R3 all clear", 32'(irq_o), 0);

        // R10 one-shot
        wr(base(2) + 8'h4, 32'd2);
        wr(base(2), 32'h81);
        pulse(0, 2);
        rd(8'h04, v); chk("R10 status", v, 32'(1 << 2));
        chk("R10 irq", 32'(irq_o), 32'(1 << 2));
        rd(base(2), v); chk("R10 run cleared", v, 32'h80);
        rd(base(2) + 8'h8, v); chk("R10 count zero", v, 0);
        wr(8'h04, 32'h3F);
        pulse(0, 5);
        rd(8'h04, v); chk("R10 stays stopped", v, 0);
        rd(base(2) + 8'h8, v); chk("R10 count held", v, 0);

        // R11 reload bit, R7 start/stop
        wr(base(3) + 8'h4, 32'd5);
        wr(base(3), 32'h01);
        pulse(0, 2);
        rd(base(3) + 8'h8, v); chk("R7 running", v, 3);
        wr(base(3), 32'h03);
        rd(base(3) + 8'h8, v); chk("R11 reload", v, 5);
        wr(base(3), 32'h00);
        pulse(0, 3);
        rd(base(3) + 8'h8, v); chk("R7 stopped", v, 5);
        wr(base(3), 32'h01);
        pulse(0, 1);
        rd(base(3) + 8'h8, v); chk("R7 restart", v, 4);
        wr(base(3), 32'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule